// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels gets the bus when several raise a transfer request in the same cycle. A 2-bit mode input picks one of three schemes. The first is a linear fixed order. The second is a fixed order in which channel 1 drops to the bottom. The third is a rotating order. Each grant covers exactly one single-transfer bus tenure. The grant is held until the transfer-done strobe arrives, the bus is then released, and arbitration runs again.

The arbiter samples the requests only when it holds no grant. It registers the winner and presents it both as a one-hot vector and as a channel index, together with a valid flag. The mode is read only at that sampling point, so changing it during a transfer cannot disturb the grant in flight. A rotation pointer records which channel comes first in the rotating order. It advances on every completed transfer, whatever the current mode.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant` is 4'b0000, `grant_vld` is 0, `grant_idx` is 0, and the rotating order starts with channel 0 first (0, 1, 2, 3).
- R2: While no grant is held, a cycle whose `req` is zero leaves `grant` at zero and `grant_vld` low. A nonzero `req` sampled at a rising edge yields `grant_vld` high and a grant to a requesting channel right after that edge.
- R3: With `mode` 2'b00, and also with the spare code 2'b11, the winner is the first requesting channel in the order 0, 1, 2, 3.
- R4: With `mode` 2'b01, the winner is the first requesting channel in the order 0, 2, 3, 1.
- R5: With `mode` 2'b10, the winner is the first requesting channel in the order starting at the rotation pointer and counting upward modulo 4.
- R6: While a grant is held and `xfer_done` is low, `grant` and `grant_idx` stay unchanged, whatever happens on `req` and `mode`.
- R7: `xfer_done` high at an edge while a grant is held drops `grant_vld` and `grant` to zero after that edge. Arbitration then runs at the next edge. `xfer_done` while no grant is held has no effect.
- R8: Each completed transfer, in any mode, sets the rotation pointer to the channel after the one just served (modulo 4). That channel becomes first in the rotating order and the served channel becomes last.
- R9: `grant` is the one-hot decode of `grant_idx` (bit n for channel n) when `grant_vld` is high, and zero when it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Transfer request, bit n for channel n |
| mode | input | 2 | 00 linear fixed, 01 fixed 0-2-3-1, 10 rotating, 11 as 00 |
| xfer_done | input | 1 | Current transfer finished |
| grant | output | 4 | One-hot grant |
| grant_idx | output | 2 | Index of granted channel |
| grant_vld | output | 1 | A grant is held |

## Verification
On every cycle the assertions check several properties. A grant stays frozen until the done strobe. The strobe releases the bus on the next cycle. An idle cycle without requests stays idle, and any new grant goes to a channel that was requesting. Channel 0 always wins in the fixed modes. They also check that the one-hot vector matches the index. The exact winner under the second fixed order and under rotation, and the advance of the rotation pointer across modes, are shown only by the bench's cycle-accurate reference model running directed and random request patterns.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [1:0]     mode,
  input  logic           xfer_done,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  grant_idx,
  output logic           grant_vld
);

  localparam logic [1:0] M_LIN = 2'b00;
  localparam logic [1:0] M_ALT = 2'b01;
  localparam logic [1:0] M_ROT = 2'b10;

  logic [IW-1:0] rot_top;
  logic [IW-1:0] win_idx;
  logic          win_any;

  function automatic logic [IW-1:0] slot_ch(input logic [1:0] m, input logic [IW-1:0] top,
                                            input int p);
    logic [IW-1:0] c;
    c = IW'(p);
    if (m == M_ALT)
      c = (p == 0) ? IW'(0) : (p == NCH-1) ? IW'(1) : IW'(p + 1);
    else if (m == M_ROT)
      c = top + IW'(p);
    return c;
  endfunction

  always_comb begin
    win_idx = '0;
    win_any = 1'b0;
    for (int p = NCH-1; p >= 0; p--) begin
      if (req[slot_ch(mode, rot_top, p)]) begin
        win_idx = slot_ch(mode, rot_top, p);
        win_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_vld <= 1'b0;
      grant_idx <= '0;
      rot_top   <= '0;
    end else if (grant_vld) begin
      if (xfer_done) begin
        grant_vld <= 1'b0;
        rot_top   <= grant_idx + 1'b1;
      end
    end else if (win_any) begin
      grant_vld <= 1'b1;
      grant_idx <= win_idx;
    end
  end

  assign grant = grant_vld ? (NCH'(1) << grant_idx) : '0;

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done) |=> (grant_vld && $stable(grant_idx)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && xfer_done) |=> (!grant_vld && grant == '0));

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req == '0) |=> !grant_vld);

  a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req != '0) |=> (grant_vld && ($past(req) & grant) != '0));

  a_r3_r4_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req[0] && mode != M_ROT) |=> (grant_idx == '0));

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_vld == (grant != '0)) && (!grant_vld || grant[grant_idx]));

  logic unused_ok;
  assign unused_ok = (M_LIN == 2'b00);

endmodule

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] req = 0;
  logic [1:0] mode = 0;
  logic xfer_done = 0;
  logic [3:0] grant;
  logic [1:0] grant_idx;
  logic grant_vld;

  int checks = 0, errors = 0;
  string tag = "R1";

  int m_vld = 0, m_idx = 0, m_top = 0;

  always #5 clk = ~clk;

  dma_prio_arb dut_i (.clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld));

  function automatic int order_at(int md, int top, int p);
    int alt[4] = '{0, 2, 3, 1};
    if (md == 1) return alt[p];
    if (md == 2) return (top + p) % 4;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = 0; m_idx = 0; m_top = 0;
    end else if (m_vld != 0) begin
      if (xfer_done) begin m_vld = 0; m_top = (m_idx + 1) % 4; end
    end else begin
      for (int p = 0; p < 4; p++) begin
        int c;
        c = order_at(mode, m_top, p);
        if (m_vld == 0 && req[c]) begin m_vld = 1; m_idx = c; end
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] eg;
    eg = (m_vld != 0) ? (4'b1 << m_idx) : 4'b0;
    checks++;
    if (grant !== eg || grant_vld !== (m_vld != 0) || (m_vld != 0 && grant_idx !== 2'(m_idx))) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d vld=%b expected grant=%b idx=%0d vld=%0d",
               tag, grant, grant_idx, grant_vld, eg, m_idx, m_vld);
    end
  end

  task automatic step(input logic [3:0] r, input logic [1:0] m, input logic d);
    @(negedge clk);
    req = r; mode = m; xfer_done = d;
  endtask

  task automatic direct(input string t, input int exp_idx);
    @(negedge clk);
    #1;
    checks++;
    if (!grant_vld || grant_idx !== 2'(exp_idx)) begin
      errors++;
      $display("FAIL %s: idx=%0d vld=%b expected idx=%0d vld=1", t, grant_idx, grant_vld, exp_idx);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R7";
    step(4'b0000, 2'b00, 1); step(4'b0000, 2'b00, 1);
    tag = "R2";
    step(4'b0000, 2'b10, 0); step(4'b0000, 2'b01, 0);
    tag = "R3";
    step(4'b1110, 2'b00, 0); direct("R3", 1);
    tag = "R6";
    step(4'b0001, 2'b01, 0); step(4'b1000, 2'b10, 0); step(4'b0000, 2'b00, 0);
    tag = "R7";
    step(4'b1111, 2'b11, 1); step(4'b1111, 2'b11, 0); direct("R3", 0);
    step(4'b0000, 2'b11, 1); step(4'b1100, 2'b11, 0); direct("R3", 2);
    step(4'b0000, 2'b01, 1);
    tag = "R4";
    step(4'b1010, 2'b01, 0); direct("R4", 3);
    step(4'b0000, 2'b01, 1); step(4'b0110, 2'b01, 0); direct("R4", 2);
    step(4'b0000, 2'b01, 1); step(4'b0011, 2'b01, 0); direct("R4", 0);
    step(4'b0000, 2'b01, 1);
    tag = "R8";
    step(4'b1111, 2'b10, 0); direct("R8", 1);
    tag = "R5";
    for (int k = 0; k < 6; k++) begin
      step(4'b1111, 2'b10, 1);
      step(4'b1111, 2'b10, 0);
    end
    step(4'b1111, 2'b10, 1);
    step(4'b0101, 2'b10, 0); direct("R5", 0);
    step(4'b0000, 2'b10, 1); step(4'b0101, 2'b10, 0); direct("R5", 2);
    step(4'b0000, 2'b10, 1);
    tag = "R9";
    for (int k = 0; k < 2000; k++) begin
      step(4'($urandom), 2'($urandom), 1'(($urandom % 3) == 0));
    end
    step(4'b0000, 2'b00, 1);
    step(4'b0000, 2'b00, 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule